// File: doc/BRIEF.md
# Watchdog External Reset Pulse Generator

When a watchdog timer expires, this block produces a single timed pulse on an external reset pin. The length of the pulse comes from a width field held in one 32-bit configuration register, counted in ticks of a 1 MHz enable strobe. A stored width of N gives a pulse of N+1 ticks. The reset value of the width is 0xFF, which gives 256 µs.

Polarity and drive style live in the same register, but plain writes cannot change them. Each of the two settings changes only when a key byte is written to bits 31:24. A write whose top byte is not one of the four keys leaves both settings as they were, and it still updates the width bits. In open-drain style the pin level is held at 0 and the output-enable carries the pulse. In push-pull style the output-enable stays high and the pin carries the level.

The pulse timer is a two-state machine. In state `PS_IDLE`, the START transition moves to `PS_DRIVE` on the clock edge that samples `expire`, and at that point the current width is captured. In `PS_DRIVE`, the HOLD transition stays in the state and counts ticks. The FINISH transition returns to `PS_IDLE` on the tick at which the count equals the captured width.

Top module: `xrst_pulse_gen`

## Requirements
- R1: After reset, `rd_data` reads 0x000000FF (active-low, open-drain, width 0xFF), and both `pin_out` and `pin_oe` are 0.
- R2: Every write stores `wr_data[19:0]` into the width field, which reads back on `rd_data[19:0]`. Bits 29:20 always read 0.
- R3: A write with top byte 0xA5 sets `rd_data[31]` to 1 (active-high). A write with top byte 0x5A sets it to 0 (active-low).
- R4: A write with top byte 0xA8 sets `rd_data[30]` to 1 (push-pull). A write with top byte 0x8A sets it to 0 (open-drain).
- R5: A write with any other top byte leaves `rd_data[31:30]` unchanged and still updates the width field.
- R6: When `expire` is sampled in `PS_IDLE`, the pulse is asserted from the next cycle. It stays asserted for exactly width+1 tick strobes, the last of which ends it. Cycles without a tick do not advance the count.
- R7: `expire` sampled while a pulse is asserted has no effect, including on the cycle whose tick ends the pulse. The pulse is not lengthened and no second pulse follows.
- R8: The width is captured at START. A width write during a pulse does not change that pulse's length and applies to the next pulse.
- R9: In open-drain style (`rd_data[30]`=0), `pin_out` is always 0 and `pin_oe` is 1 exactly while the pulse is asserted.
- R10: In push-pull style (`rd_data[30]`=1), `pin_oe` is always 1. `pin_out` equals `rd_data[31]` during the pulse and its inverse otherwise.
- R11: A width of 0 gives a pulse of exactly one tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read value: [31] active-high, [30] push-pull, [19:0] width |
| tick_1us | input | 1 | 1 MHz tick enable, one cycle wide |
| expire | input | 1 | Watchdog expiry trigger |
| pin_out | output | 1 | Level for the external reset pad |
| pin_oe | output | 1 | Output-enable for the external reset pad |

## Verification
Two situations are hard to reach from the ports. One is an `expire` that arrives in the very cycle whose tick ends a pulse. The other is a width write that lands while a pulse is running. Both depend on hitting a single cycle inside the pulse. The bench reaches them by driving `expire` and `wr_en` from inside the loop that measures the pulse, keyed to the cycle index within that pulse. It then checks that the pin returns to idle one cycle later and stays there. Sparse tick patterns (one strobe every third cycle) show that cycles without a tick leave the count untouched.

// File: rtl/xrst_pulse_pkg.sv
package xrst_pulse_pkg;

    // Timer states
    typedef enum logic [0:0] {
        PS_IDLE  = 1'b0,
        PS_DRIVE = 1'b1
    } pulse_state_e;

    // Top-byte key values
    localparam logic [7:0] KEY_POL_HIGH = 8'hA5;
    localparam logic [7:0] KEY_POL_LOW  = 8'h5A;
    localparam logic [7:0] KEY_DRV_PP   = 8'hA8;
    localparam logic [7:0] KEY_DRV_OD   = 8'h8A;

    // Fixed read-back positions of the keyed settings
    localparam int POL_BIT = 31;
    localparam int DRV_BIT = 30;

    typedef struct packed {
        logic set;
        logic val;
    } key_hit_t;

    function automatic key_hit_t decode_pol(input logic [7:0] top);
        key_hit_t h;
        h.set = (top == KEY_POL_HIGH) || (top == KEY_POL_LOW);
        h.val = (top == KEY_POL_HIGH);
        return h;
    endfunction

    function automatic key_hit_t decode_drv(input logic [7:0] top);
        key_hit_t h;
        h.set = (top == KEY_DRV_PP) || (top == KEY_DRV_OD);
        h.val = (top == KEY_DRV_PP);
        return h;
    endfunction

endpackage

// File: rtl/xrst_cfg_reg.sv
module xrst_cfg_reg
    import xrst_pulse_pkg::*;
#(
    parameter int                 WIDTH_W       = 20,
    parameter logic [WIDTH_W-1:0] DEFAULT_WIDTH = WIDTH_W'(8'hFF)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         wr_top,
    input  logic [WIDTH_W-1:0] wr_width,
    output logic [WIDTH_W-1:0] width,
    output logic               pol_high,
    output logic               push_pull,
    output logic [31:0]        rd_data
);
    localparam int PAD_W = 30 - WIDTH_W;

    key_hit_t pol_hit;
    key_hit_t drv_hit;

    always_comb begin
        pol_hit = decode_pol(wr_top);
        drv_hit = decode_drv(wr_top);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width     <= DEFAULT_WIDTH;
            pol_high  <= 1'b0;
            push_pull <= 1'b0;
        end else if (wr_en) begin
            width <= wr_width;
            if (pol_hit.set) pol_high  <= pol_hit.val;
            if (drv_hit.set) push_pull <= drv_hit.val;
        end
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign rd_data = {pol_high, push_pull, {PAD_W{1'b0}}, width};
        end else begin : g_nopad
            assign rd_data = {pol_high, push_pull, width};
        end
    endgenerate

endmodule

// File: rtl/xrst_pulse_fsm.sv
module xrst_pulse_fsm
    import xrst_pulse_pkg::*;
#(
    parameter int WIDTH_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig,
    input  logic               tick,
    input  logic [WIDTH_W-1:0] width,
    output logic               active
);
    pulse_state_e       state;
    pulse_state_e       state_nx;
    logic [WIDTH_W-1:0] cnt;
    logic [WIDTH_W-1:0] lim;
    logic               last_tick;

    assign last_tick = tick && (cnt == lim);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PS_IDLE;
        else        state <= state_nx;
    end

    // Next state: START, HOLD, FINISH
    always_comb begin
        state_nx = state;
        unique case (state)
            PS_IDLE:  if (trig)      state_nx = PS_DRIVE;
            PS_DRIVE: if (last_tick) state_nx = PS_IDLE;
        endcase
    end

    // Tick counter and captured width
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            lim <= '0;
        end else if (state == PS_IDLE) begin
            if (trig) begin
                cnt <= '0;
                lim <= width;
            end
        end else if (tick && !last_tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        active = 1'b0;
        unique case (state)
            PS_IDLE:  active = 1'b0;
            PS_DRIVE: active = 1'b1;
        endcase
    end

endmodule

// File: rtl/xrst_pad_drive.sv
module xrst_pad_drive (
    input  logic active,
    input  logic pol_high,
    input  logic push_pull,
    output logic pin_out,
    output logic pin_oe
);
    always_comb begin
        if (push_pull) begin
            pin_oe  = 1'b1;
            pin_out = active ? pol_high : !pol_high;
        end else begin
            pin_oe  = active;
            pin_out = 1'b0;
        end
    end
endmodule

// File: rtl/xrst_pulse_gen.sv
module xrst_pulse_gen
    import xrst_pulse_pkg::*;
#(
    parameter int WIDTH_W = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic        tick_1us,
    input  logic        expire,
    output logic        pin_out,
    output logic        pin_oe
);
    logic [WIDTH_W-1:0] width;
    logic               pol_high;
    logic               push_pull;
    logic               pulse_on;

    xrst_cfg_reg #(.WIDTH_W(WIDTH_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_top   (wr_data[31:24]),
        .wr_width (wr_data[WIDTH_W-1:0]),
        .width    (width),
        .pol_high (pol_high),
        .push_pull(push_pull),
        .rd_data  (rd_data)
    );

    xrst_pulse_fsm #(.WIDTH_W(WIDTH_W)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (expire),
        .tick  (tick_1us),
        .width (width),
        .active(pulse_on)
    );

    xrst_pad_drive u_drv (
        .active   (pulse_on),
        .pol_high (pol_high),
        .push_pull(push_pull),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

endmodule

// File: rtl/xrst_pulse_gen_chk.sv
module xrst_pulse_gen_chk #(
    parameter int WIDTH_W = 20
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        tick_1us,
    input logic        expire,
    input logic        pin_out,
    input logic        pin_oe,
    input logic        pulse_on
);
    logic no_key;
    assign no_key = !(wr_data[31:24] inside {8'hA5, 8'h5A, 8'hA8, 8'h8A});

    p_width_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[WIDTH_W-1:0] == $past(wr_data[WIDTH_W-1:0]));

    p_pol_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[31:24] == 8'hA5) |=> rd_data[31]);

    p_pol_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[31:24] == 8'h5A) |=> !rd_data[31]);

    p_drv_pp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[31:24] == 8'hA8) |=> rd_data[30]);

    p_drv_od_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[31:24] == 8'h8A) |=> !rd_data[30]);

    p_keep_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && no_key) |=> rd_data[31:30] == $past(rd_data[31:30]));

    p_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_on && expire) |=> pulse_on);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_on && !tick_1us) |=> pulse_on);

    p_od_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[30] |-> (!pin_out && pin_oe == pulse_on));

    p_pp_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[30] |-> (pin_oe && pin_out == (pulse_on ~^ rd_data[31])));

endmodule

bind xrst_pulse_gen xrst_pulse_gen_chk #(.WIDTH_W(WIDTH_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .tick_1us(tick_1us),
    .expire  (expire),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .pulse_on(pulse_on)
);

// File: tb/test_xrst_pulse_gen.sv
`timescale 1ns/1ps
module test_xrst_pulse_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        tick_1us = 1'b0;
    logic        expire = 1'b0;
    logic        pin_out;
    logic        pin_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    xrst_pulse_gen i_xrst_pulse_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .tick_1us(tick_1us), .expire(expire),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // {write data, expected read value}
    localparam logic [63:0] VEC [8] = '{
        {32'h0001_2345, 32'h0001_2345},  // R5 R2 no key
        {32'hA500_0010, 32'h8000_0010},  // R3 high
        {32'hA800_0020, 32'hC000_0020},  // R4 push-pull
        {32'h7FFF_FFFF, 32'hC00F_FFFF},  // R2 R5 bits 29:20 dropped
        {32'h5A00_0003, 32'h4000_0003},  // R3 low
        {32'h8A00_0004, 32'h0000_0004},  // R4 open-drain
        {32'hA400_0005, 32'h0000_0005},  // R5 near key
        {32'hFF00_0006, 32'h0000_0006}   // R5 other byte
    };
    string vtag [8] = '{"R5", "R3", "R4", "R2", "R3", "R4", "R5", "R5"};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    // Measures one pulse; returns its length in cycles, a count of bad
    // pad cycles and whether the pin is asserted one cycle after the end.
    task automatic pulse(input int per, input bit pp, input bit ah,
                         input int retrig_at, input int wr_at, input logic [31:0] wv,
                         output int cyc, output int badpad, output bit after);
        int ph = 0;
        @(negedge clk); expire = 1'b1; tick_1us = 1'b0;
        @(negedge clk); expire = 1'b0;
        cyc = 0; badpad = 0;
        while ((pp ? (pin_out == ah) : pin_oe) && cyc < 5000) begin
            cyc++;
            if (pp ? !pin_oe : pin_out) badpad++;
            tick_1us = (ph == per - 1);
            ph = (ph + 1) % per;
            expire = (cyc == retrig_at);
            wr_en = (cyc == wr_at);
            wr_data = wv;
            @(negedge clk);
        end
        tick_1us = 1'b0; expire = 1'b0; wr_en = 1'b0; wr_data = '0;
        @(negedge clk);
        after = pp ? (pin_out == ah) : pin_oe;
    endtask

    initial begin
        int c, b;
        bit a;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rd_data", rd_data, 32'h0000_00FF);
        check("R1 pins", {30'd0, pin_out, pin_oe}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rd_data after release", rd_data, 32'h0000_00FF);

        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][63:32]);
            check(vtag[i], rd_data, VEC[i][31:0]);
        end

        // R9 open-drain active-low, width 3
        wr(32'h5A00_0003);
        check("R9 idle pins", {30'd0, pin_out, pin_oe}, 32'd0);
        pulse(1, 1'b0, 1'b0, 0, 0, 32'h0, c, b, a);
        check("R6 length W=3", c, 4);
        check("R9 pin low in pulse", b, 0);
        check("R6 idle after", {31'd0, a}, 0);

        // R11 width 0
        wr(32'h0000_0000);
        pulse(1, 1'b0, 1'b0, 0, 0, 32'h0, c, b, a);
        check("R11 length W=0", c, 1);

        // R6 sparse ticks
        wr(32'h0000_0003);
        pulse(3, 1'b0, 1'b0, 0, 0, 32'h0, c, b, a);
        check("R6 length W=3 per=3", c, 12);

        // R7 retrigger mid-pulse and on the final tick
        pulse(1, 1'b0, 1'b0, 2, 0, 32'h0, c, b, a);
        check("R7 mid retrigger length", c, 4);
        pulse(1, 1'b0, 1'b0, 4, 0, 32'h0, c, b, a);
        check("R7 final-tick retrigger length", c, 4);
        check("R7 no second pulse", {31'd0, a}, 0);
        repeat (3) @(negedge clk);
        check("R7 still idle", {31'd0, pin_oe}, 0);

        // R8 width write during pulse
        wr(32'h0000_0005);
        pulse(1, 1'b0, 1'b0, 0, 1, 32'h0000_0002, c, b, a);
        check("R8 running pulse keeps width", c, 6);
        check("R8 written width read", rd_data, 32'h0000_0002);
        pulse(1, 1'b0, 1'b0, 0, 0, 32'h0, c, b, a);
        check("R8 next pulse uses new width", c, 3);

        // R10 push-pull active-low
        wr(32'hA800_0002);
        check("R10 idle pins pp low", {30'd0, pin_out, pin_oe}, 32'd3);
        pulse(1, 1'b1, 1'b0, 0, 0, 32'h0, c, b, a);
        check("R10 length pp low", c, 3);
        check("R10 oe held", b, 0);

        // R10 push-pull active-high
        wr(32'hA500_0001);
        check("R10 idle pins pp high", {30'd0, pin_out, pin_oe}, 32'd1);
        pulse(1, 1'b1, 1'b1, 0, 0, 32'h0, c, b, a);
        check("R10 length pp high", c, 2);
        check("R10 back to idle", {30'd0, pin_out, pin_oe}, 32'd1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule